// File: doc/BRIEF.md
# Timebase Counter Interrupt Aggregator

This block holds a free-running 16-bit timebase counter and the event flags that are collected around it. The counter advances by one on each clock edge where the run control and the count-enable strobe are both high. The count-enable strobe lets an external prescaler set the count rate. Two flags come from the counter. One is set when the full count wraps to zero. The other is set when a selectable low slice of the counter, 8 to 11 bits wide, rolls over. Three more flags are set by single-cycle event pulses from three channel datapaths that sit outside this block.

All five flags are sticky. Each flag is set whenever its trigger occurs, even when its enable is low. Software clears a flag by writing a mask in which that flag's bit is 0. Each flag has its own enable bit. The enabled flags are ORed into one interrupt request. That request is then gated by a peripheral-level enable and a global enable, and it leaves the block through a register so that the output does not glitch.

Flag bit order on `flags_o`, `src_en_i` and `clr_data_i`:
- bit 0: full overflow
- bit 1: intermediate overflow
- bits 2, 3 and 4: channels 0, 1 and 2

Top module: `tmr_irq_agg`

## Requirements
- R1: After reset `count_o` advances by exactly 1 on each rising edge where `run_i` and `tick_i` are both 1. It keeps its value on every other edge.
- R2: Flag bit 0 is set on the edge where the counter wraps from 0xFFFF to 0x0000.
- R3: Flag bit 1 is set on a counting edge where the low N bits of the counter are all ones. N is 8 + `wsel_i`, so 00 selects 8 bits, 01 selects 9, 10 selects 10 and 11 selects 11. A rollover of fewer than N low bits does not set it.
- R4: A 1 on `chan_evt_i[k]` sets flag bit 2+k on that rising edge.
- R5: Every flag is set by its trigger whatever the value of its bit in `src_en_i`.
- R6: Flags hold until cleared. An edge with `clr_we_i` = 1 clears each flag whose `clr_data_i` bit is 0. Flags whose `clr_data_i` bit is 1 are left as they are.
- R7: When a set event and a clear of the same flag fall on the same edge, the flag ends up set.
- R8: `irq_o` is a register loaded on each edge with OR(flags AND `src_en_i`) AND `periph_en_i` AND `global_en_i`. It therefore follows a flag change one cycle later.
- R9: While `rst_ni` is low, `count_o`, `flags_o` and `irq_o` are all 0.
- R10: While `run_i` is 0 the counter does not move and no overflow flag is set, even when `tick_i` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter run control |
| tick_i | input | 1 | Count-enable strobe from a prescaler |
| wsel_i | input | 2 | Width select for the intermediate overflow |
| chan_evt_i | input | 3 | Channel event pulses |
| src_en_i | input | 5 | Per-flag interrupt enables |
| periph_en_i | input | 1 | Peripheral-level interrupt enable |
| global_en_i | input | 1 | Global interrupt enable |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_data_i | input | 5 | Clear write data; 0 clears the flag, 1 keeps it |
| flags_o | output | 5 | Event flags |
| count_o | output | 16 | Counter value |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The counter, every flag set and every flag clear take effect on the same edge that samples the stimulus. `irq_o` follows one edge after the flags or enables it depends on. The bench drives all inputs just after a falling edge and reads the outputs at a later falling edge, so each result is read one half-period after the edge that produced it. The IRQ checks read the output once right after the flag clears, where it must still be high, and again one cycle later, where it must be low. This pins the one-cycle lag exactly. Rollover checks read the flag one count before the rollover, where it must be clear, and again at the rollover, where it must be set. The 9-bit case also checks that a rollover of only the low 8 bits leaves the flag clear.

// File: rtl/tmr_irq_agg_pkg.sv
package tmr_irq_agg_pkg;
  localparam int unsigned SRC_FULL = 0;
  localparam int unsigned SRC_MID  = 1;
  localparam int unsigned SRC_CH0  = 2;
endpackage

// File: rtl/tia_timebase.sv
module tia_timebase #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MID_BASE = 8,
  parameter int unsigned WSEL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_hit_o,
  output logic              mid_hit_o
);
  localparam int unsigned NSEL = 1 << WSEL_W;

  logic [CNT_W-1:0] count_q;
  logic             inc;
  logic [NSEL-1:0]  low_ones;

  assign inc = run_i & tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  // one all-ones detector per selectable slice width
  for (genvar v = 0; v < NSEL; v++) begin : g_slice
    assign low_ones[v] = &count_q[MID_BASE+v-1:0];
  end

  assign full_hit_o = inc & (&count_q);
  assign mid_hit_o  = inc & low_ones[wsel_i];
  assign count_o    = count_q;

  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |=> count_q == $past(count_q) + 1'b1);
  // R10
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_q));
endmodule

// File: rtl/tia_flag_bank.sv
module tia_flag_bank #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_data_i,
  output logic [NSRC-1:0] flags_o
);
  logic [NSRC-1:0] flags_q, clr_mask;

  assign clr_mask = clr_we_i ? ~clr_data_i : '0;

  // set takes precedence over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_mask) | set_i;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R6
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_q[i] && !clr_mask[i] |=> flags_q[i]);
    // R5 R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/tia_irq_combine.sv
module tia_irq_combine #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] flags_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            periph_en_i,
  input  logic            global_en_i,
  output logic            irq_o
);
  logic pending, irq_q;

  assign pending = |(flags_i & src_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pending & periph_en_i & global_en_i;
  end

  assign irq_o = irq_q;

  // R8
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(periph_en_i && global_en_i) |=> !irq_q);
  // R8
  no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i & src_en_i) == '0 |=> !irq_q);
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tmr_irq_agg_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned MID_BASE = 8,
  parameter int unsigned WSEL_W   = 2,
  localparam int unsigned NSRC    = NUM_CH + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [NUM_CH-1:0] chan_evt_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              periph_en_i,
  input  logic              global_en_i,
  input  logic              clr_we_i,
  input  logic [NSRC-1:0]   clr_data_i,
  output logic [NSRC-1:0]   flags_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  logic            full_hit, mid_hit;
  logic [NSRC-1:0] set_vec;

  tia_timebase #(.CNT_W(CNT_W), .MID_BASE(MID_BASE), .WSEL_W(WSEL_W)) u_timebase (
    .clk_i, .rst_ni, .run_i, .tick_i, .wsel_i,
    .count_o, .full_hit_o(full_hit), .mid_hit_o(mid_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SRC_FULL] = full_hit;
    set_vec[SRC_MID]  = mid_hit;
    set_vec[SRC_CH0 +: NUM_CH] = chan_evt_i;
  end

  tia_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_we_i, .clr_data_i, .flags_o
  );

  tia_irq_combine #(.NSRC(NSRC)) u_irq (
    .clk_i, .rst_ni, .flags_i(flags_o), .src_en_i, .periph_en_i, .global_en_i, .irq_o
  );

  // R2
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && (&count_o)) |=> (flags_o[SRC_FULL] && count_o == '0));
  // R4
  chan_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_evt_i[0] |=> flags_o[SRC_CH0]);
endmodule

// File: tb/tmr_irq_agg_bench.sv
module tmr_irq_agg_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 0, tick_i = 0, periph_en_i = 0, global_en_i = 0, clr_we_i = 0;
  logic [1:0]  wsel_i = 0;
  logic [2:0]  chan_evt_i = 0;
  logic [4:0]  src_en_i = 0, clr_data_i = 5'h1f;
  logic [4:0]  flags_o;
  logic [15:0] count_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tmr_irq_agg u_tmr_irq_agg (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic adv(int n);
    tick_i = 1;
    step(n);
    tick_i = 0;
    exp_cnt = (exp_cnt + n) & 16'hffff;
  endtask

  task automatic clear_all();
    clr_we_i = 1; clr_data_i = 5'h00;
    step();
    clr_we_i = 0; clr_data_i = 5'h1f;
  endtask

  task automatic t_reset();
    chk("R9 count", count_o, 0);
    chk("R9 flags", flags_o, 0);
    chk("R9 irq", irq_o, 0);
  endtask

  task automatic t_count();
    run_i = 1;
    adv(5);
    chk("R1 count after 5 ticks", count_o, exp_cnt);
    step(3);
    chk("R1 hold without tick", count_o, exp_cnt);
    run_i = 0; tick_i = 1;
    step(4);
    tick_i = 0;
    chk("R10 hold with run low", count_o, exp_cnt);
    run_i = 1;
  endtask

  task automatic t_mid();
    wsel_i = 2'b00;
    adv(16'h00ff - exp_cnt);
    chk("R3 8b no flag before roll", flags_o[1], 0);
    adv(1);
    chk("R3 8b flag at roll", flags_o[1], 1);
    chk("R3 count 0x100", count_o, 16'h0100);
    clear_all();
    chk("R6 cleared by 0 write", flags_o, 0);
    wsel_i = 2'b01;
    adv(16'h01ff - exp_cnt);
    chk("R3 9b no flag before roll", flags_o[1], 0);
    adv(1);
    chk("R3 9b flag at roll", flags_o[1], 1);
    clear_all();
    adv(16'h0300 - exp_cnt);
    chk("R3 9b ignores 8b roll", flags_o[1], 0);
    wsel_i = 2'b10;
    adv(16'h0400 - exp_cnt);
    chk("R3 10b flag at roll", flags_o[1], 1);
    clear_all();
    wsel_i = 2'b11;
    adv(16'h07ff - exp_cnt);
    chk("R3 11b no flag before roll", flags_o[1], 0);
    adv(1);
    chk("R3 11b flag at roll", flags_o[1], 1);
    chk("R2 no full flag mid-range", flags_o[0], 0);
    clear_all();
  endtask

  task automatic t_chan_irq();
    src_en_i = 0;
    chan_evt_i = 3'b010;
    step();
    chan_evt_i = 0;
    chk("R4 R5 ch1 flag without enable", flags_o, 5'b01000);
    step();
    chk("R8 irq low with no enable", irq_o, 0);
    src_en_i = 5'b01000; periph_en_i = 1; global_en_i = 0;
    step(2);
    chk("R8 irq low with global off", irq_o, 0);
    global_en_i = 1;
    step();
    chk("R8 irq high one cycle after enables", irq_o, 1);
    clr_we_i = 1; clr_data_i = 5'h1f;
    step();
    clr_we_i = 0;
    chk("R6 write of 1s keeps flag", flags_o, 5'b01000);
    clr_we_i = 1; clr_data_i = 5'b10111;
    step();
    clr_we_i = 0; clr_data_i = 5'h1f;
    chk("R6 ch1 cleared", flags_o, 0);
    chk("R8 irq still high one cycle after clear", irq_o, 1);
    step();
    chk("R8 irq low two cycles after clear", irq_o, 0);
    chan_evt_i = 3'b100; clr_we_i = 1; clr_data_i = 5'b01111;
    step();
    chan_evt_i = 0; clr_we_i = 0; clr_data_i = 5'h1f;
    chk("R7 set wins over clear", flags_o, 5'b10000);
    clear_all();
  endtask

  task automatic t_full();
    src_en_i = 5'b00001; periph_en_i = 1; global_en_i = 1;
    adv(16'hffff - exp_cnt);
    chk("R2 no wrap flag at 0xffff", flags_o[0], 0);
    chk("R1 count 0xffff", count_o, 16'hffff);
    adv(1);
    chk("R2 wrap flag set", flags_o[0], 1);
    chk("R2 count wraps to 0", count_o, 0);
    step();
    chk("R8 irq from wrap flag", irq_o, 1);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_count();
    t_mid();
    t_chan_irq();
    t_full();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule